// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break Handling

This block turns one asynchronous serial line into assembled characters. A 16x oversampling enable paces it. After the line falls, the receiver rechecks it half a bit later to confirm the start bit. It then samples each later bit once per bit time at the bit centre, least significant bit first. The character is complete at the centre of the stop bit. The receiver then presents the byte together with its parity-error, framing-error and break flags, and gives a one-cycle valid strobe.

A frame that stays low from the start bit through the stop bit is reported as a break. The result is a zero byte with the break flag set, and a one-cycle change-of-break strobe. The receiver then ignores the line until it has been high on two successive clock edges. At that point it strobes change-of-break again and resumes the search for a start bit.

A character with a low stop bit that is not a break is reported with a framing error. If the line is still low half a bit after such a stop bit, that point is taken as a confirmed start bit for the next character. Mode inputs set the character length (5 to 8 bits) and the parity (none, even or odd). Any FIFO, host interface and transmitter are connected outside this block.

Top module: `serial_rx_brk`

## Requirements
- R1: After the synchronized line falls, it is rechecked half a bit time (8 oversample ticks) later. If it is high then, no strobe is raised and the receiver returns to searching for a start bit.
- R2: A confirmed start bit raises start_o for exactly one clock cycle, once per confirmed start.
- R3: Data bits are sampled at bit centres, least significant bit first. At the stop-bit centre, data_o is updated and valid_o pulses for exactly one clock cycle. data_o and the flags hold until the next valid_o.
- R4: len_i selects the data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of data_o are zero.
- R5: par_i selects the parity: 0 none, 1 even, 2 odd, 3 none. With parity on, perr_o is set when the XOR of the data bits and the parity bit is 1 (even) or 0 (odd); otherwise perr_o is 0.
- R6: A low stop bit on a frame that is not entirely low sets ferr_o, with brk_o clear and the received data on data_o.
- R7: A frame with start, all data bits, the parity bit (if enabled) and the stop bit all low gives data_o = 0 with brk_o = 1, ferr_o = 0, and a one-cycle brk_chg_o at the same time as valid_o.
- R8: After a break, no character is assembled until the line has been high on two successive clock edges. A high lasting a single clock edge does not end the break. The end of the break raises brk_chg_o once, and the receiver then accepts characters again.
- R9: If the line is still low half a bit after a low stop bit, this counts as a confirmed start: start_o pulses and the next character is assembled from the following bit times.
- R10: While en_i is low, the receiver is idle and valid_o, start_o and brk_chg_o stay low. A character cut off by deasserting en_i is never delivered.
- R11: Under reset, data_o is 0 and all strobes and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | Oversample enable, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| len_i | input | 2 | Data bit count select |
| par_i | input | 2 | Parity mode select |
| data_o | output | 8 | Received character |
| valid_o | output | 1 | Character complete strobe |
| perr_o | output | 1 | Parity error for data_o |
| ferr_o | output | 1 | Framing error for data_o |
| brk_o | output | 1 | data_o is a break character |
| brk_chg_o | output | 1 | Break began or ended strobe |
| start_o | output | 1 | Start bit confirmed strobe |

## Verification
Characters are sent as alternating, single-bit and mixed patterns at every length. This shows that bit ordering and truncation are correct, and that upper bits are zero rather than stale. Parity frames are sent both correct and corrupted under even and odd modes, which separates the two polarities. Line patterns check each decision separately: a short low glitch (rejected start), a stop bit low for less than a bit (framing error only), a stop bit low for 1.5 bits followed by data (re-synchronized start), and a line held low for a whole frame, broken by a one-clock high glitch before a real release (break, and its two-edge end rule). Enable is dropped both before a frame and in the middle of one.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_RESYNC,
    ST_BREAK
  } rx_state_e;

  // index of the last data bit for a length code
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_tick_count.sv
module rx_tick_count #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic half_o,
  output logic full_o
);

  localparam int unsigned CW   = $clog2(OVERSAMPLE);
  localparam int unsigned HALF = OVERSAMPLE / 2;

  logic [CW-1:0] cnt_q;

  assign half_o = tick_i && (cnt_q == CW'(HALF - 1));
  assign full_o = tick_i && (cnt_q == CW'(OVERSAMPLE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (full_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import serial_rx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          rxd_i,
  input  logic          half_i,
  input  logic          full_i,
  input  logic [1:0]    len_i,
  input  logic [1:0]    par_i,
  output logic          cnt_clr_o,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o,
  output logic          brk_chg_o,
  output logic          start_o
);

  localparam int unsigned IW = $clog2(DW);

  rx_state_e     state_q;
  logic [DW-1:0] shift_q;
  logic [IW-1:0] idx_q;
  logic          pbit_q;
  logic          hi_seen_q;

  par_mode_e par_mode;
  logic      par_en;
  logic      start_ok;
  logic      all_low;
  logic      par_bad;

  assign par_mode = par_mode_e'(par_i);
  assign par_en   = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
  // half-bit recheck that confirms a start (fresh or after a low stop)
  assign start_ok = half_i && !rxd_i &&
                    ((state_q == ST_START) || (state_q == ST_RESYNC));
  assign all_low  = (shift_q == '0) && !pbit_q && !rxd_i;
  assign par_bad  = par_en && ((^shift_q) ^ pbit_q ^ (par_mode == PAR_ODD));

  assign cnt_clr_o = !en_i || (state_q == ST_IDLE) || (state_q == ST_BREAK) || start_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      idx_q     <= '0;
      pbit_q    <= 1'b0;
      hi_seen_q <= 1'b0;
      data_o    <= '0;
      valid_o   <= 1'b0;
      perr_o    <= 1'b0;
      ferr_o    <= 1'b0;
      brk_o     <= 1'b0;
      brk_chg_o <= 1'b0;
      start_o   <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      brk_chg_o <= 1'b0;
      start_o   <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (start_ok) begin
        start_o <= 1'b1;
        shift_q <= '0;
        idx_q   <= '0;
        pbit_q  <= 1'b0;
        state_q <= ST_DATA;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            hi_seen_q <= 1'b0;
            if (!rxd_i) state_q <= ST_START;
          end
          ST_START, ST_RESYNC: begin
            if (half_i) state_q <= ST_IDLE;  // line high at recheck
          end
          ST_DATA: begin
            if (full_i) begin
              shift_q[idx_q] <= rxd_i;
              if (idx_q == IW'(last_bit_idx(len_i)))
                state_q <= par_en ? ST_PAR : ST_STOP;
              else
                idx_q <= idx_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (full_i) begin
              pbit_q  <= rxd_i;
              state_q <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (full_i) begin
              valid_o <= 1'b1;
              if (all_low) begin
                data_o    <= '0;
                brk_o     <= 1'b1;
                ferr_o    <= 1'b0;
                perr_o    <= 1'b0;
                brk_chg_o <= 1'b1;
                hi_seen_q <= 1'b0;
                state_q   <= ST_BREAK;
              end else begin
                data_o  <= shift_q;
                brk_o   <= 1'b0;
                ferr_o  <= !rxd_i;
                perr_o  <= par_bad;
                state_q <= rxd_i ? ST_IDLE : ST_RESYNC;
              end
            end
          end
          ST_BREAK: begin
            if (rxd_i) begin
              if (hi_seen_q) begin
                brk_chg_o <= 1'b1;
                state_q   <= ST_IDLE;
              end
              hi_seen_q <= 1'b1;
            end else begin
              hi_seen_q <= 1'b0;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk #(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DW          = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic [1:0]    len_i,
  input  logic [1:0]    par_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o,
  output logic          brk_chg_o,
  output logic          start_o
);

  logic rxd_s;
  logic cnt_clr;
  logic half_hit;
  logic full_hit;

  rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rxd_s)
  );

  rx_tick_count #(.OVERSAMPLE(OVERSAMPLE)) i_ticks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (tick_i),
    .half_o (half_hit),
    .full_o (full_hit)
  );

  rx_frame_ctrl #(.DW(DW)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .rxd_i     (rxd_s),
    .half_i    (half_hit),
    .full_i    (full_hit),
    .len_i     (len_i),
    .par_i     (par_i),
    .cnt_clr_o (cnt_clr),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .perr_o    (perr_o),
    .ferr_o    (ferr_o),
    .brk_o     (brk_o),
    .brk_chg_o (brk_chg_o),
    .start_o   (start_o)
  );

endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [1:0]    len_i,
  input logic          rxd_s,
  input logic [DW-1:0] data_o,
  input logic          valid_o,
  input logic          ferr_o,
  input logic          brk_o,
  input logic          brk_chg_o,
  input logic          start_o
);

  p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(rxd_s));

  p_start_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && len_i == 2'd0) |-> (data_o[DW-1:5] == '0));

  p_ferr_not_brk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !(ferr_o && brk_o));

  p_brk_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && brk_o) |-> (data_o == '0 && brk_chg_o && !ferr_o));

  p_brk_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_chg_o && !valid_o) |-> ($past(rxd_s) && $past(rxd_s, 2)));

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!valid_o && !start_o && !brk_chg_o));

endmodule

bind serial_rx_brk serial_rx_brk_chk #(.DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .len_i     (len_i),
  .rxd_s     (rxd_s),
  .data_o    (data_o),
  .valid_o   (valid_o),
  .ferr_o    (ferr_o),
  .brk_o     (brk_o),
  .brk_chg_o (brk_chg_o),
  .start_o   (start_o)
);

// File: tb/test_serial_rx_brk.sv
module test_serial_rx_brk;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] len = 2'd3;
  logic [1:0] par = 2'd0;
  logic [7:0] data;
  logic       valid, perr, ferr, brk, brk_chg, start;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_start = 0, n_chg = 0;
  logic [7:0] cap_data = '0, prv_data = '0;
  logic       cap_perr = 0, cap_ferr = 0, cap_brk = 0, prv_ferr = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_brk i_serial_rx_brk (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .rxd_i(rxd),
    .len_i(len), .par_i(par), .data_o(data), .valid_o(valid), .perr_o(perr),
    .ferr_o(ferr), .brk_o(brk), .brk_chg_o(brk_chg), .start_o(start)
  );

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (valid) begin
      n_valid++;
      prv_data = cap_data; prv_ferr = cap_ferr;
      cap_data = data; cap_perr = perr; cap_ferr = ferr; cap_brk = brk;
    end
    if (start)   n_start++;
    if (brk_chg) n_chg++;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb);
    logic p = 1'b0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  // stop_low == 0: high stop bit for one bit time; else low for stop_low clocks
  task automatic send_char(input logic [7:0] d, input int nb, input int pm,
                           input logic flip, input int stop_low, input bit with_start);
    if (with_start) begin rxd = 1'b0; wait_clks(BIT_CLKS); end
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_clks(BIT_CLKS); end
    if (pm == 1 || pm == 2) begin
      rxd = par_of(d, nb) ^ (pm == 2) ^ flip;
      wait_clks(BIT_CLKS);
    end
    if (stop_low == 0) begin rxd = 1'b1; wait_clks(BIT_CLKS); end
    else begin rxd = 1'b0; wait_clks(stop_low); end
  endtask

  task automatic idle_bits(input int n);
    rxd = 1'b1;
    wait_clks(n * BIT_CLKS);
  endtask

  task automatic t_reset;
    check("R11", "data_o", data, 0);
    check("R11", "strobes", {valid, start, brk_chg}, 0);
    check("R11", "flags", {perr, ferr, brk}, 0);
  endtask

  task automatic t_basic;
    int v0 = n_valid, s0 = n_start;
    len = 2'd3; par = 2'd0;
    send_char(8'hA5, 8, 0, 0, 0, 1); idle_bits(1);
    check("R3", "valid count", n_valid - v0, 1);
    check("R3", "data A5", cap_data, 8'hA5);
    check("R2", "start count", n_start - s0, 1);
    check("R6", "no ferr", cap_ferr, 0);
    send_char(8'h01, 8, 0, 0, 0, 1);
    send_char(8'h80, 8, 0, 0, 0, 1); idle_bits(1);
    check("R3", "data 01", prv_data, 8'h01);
    check("R3", "data 80", cap_data, 8'h80);
    check("R3", "valid hold", data, 8'h80);
  endtask

  task automatic t_length;
    len = 2'd0;
    send_char(8'hF5, 5, 0, 0, 0, 1); idle_bits(1);
    check("R4", "5-bit data", cap_data, 8'h15);
    len = 2'd1;
    send_char(8'hEA, 6, 0, 0, 0, 1); idle_bits(1);
    check("R4", "6-bit data", cap_data, 8'h2A);
    len = 2'd2;
    send_char(8'hFF, 7, 0, 0, 0, 1); idle_bits(1);
    check("R4", "7-bit data", cap_data, 8'h7F);
    len = 2'd3;
  endtask

  task automatic t_parity;
    par = 2'd1;
    send_char(8'h3C, 8, 1, 0, 0, 1); idle_bits(1);
    check("R5", "even ok perr", cap_perr, 0);
    check("R5", "even ok data", cap_data, 8'h3C);
    send_char(8'h3D, 8, 1, 1, 0, 1); idle_bits(1);
    check("R5", "even bad perr", cap_perr, 1);
    par = 2'd2;
    send_char(8'h3D, 8, 2, 0, 0, 1); idle_bits(1);
    check("R5", "odd ok perr", cap_perr, 0);
    send_char(8'h3C, 8, 2, 1, 0, 1); idle_bits(1);
    check("R5", "odd bad perr", cap_perr, 1);
    par = 2'd3;
    send_char(8'h3D, 8, 0, 0, 0, 1); idle_bits(1);
    check("R5", "reserved code no parity", {cap_perr, cap_data}, 9'h03D);
    par = 2'd0;
  endtask

  task automatic t_false_start;
    int v0 = n_valid, s0 = n_start;
    rxd = 1'b0; wait_clks(8);
    idle_bits(2);
    check("R1", "glitch start count", n_start - s0, 0);
    check("R1", "glitch valid count", n_valid - v0, 0);
  endtask

  task automatic t_framing;
    int v0 = n_valid, s0 = n_start;
    send_char(8'h55, 8, 0, 0, (BIT_CLKS * 3) / 4, 1); idle_bits(2);
    check("R6", "valid count", n_valid - v0, 1);
    check("R6", "ferr", cap_ferr, 1);
    check("R6", "data", cap_data, 8'h55);
    check("R6", "brk clear", cap_brk, 0);
    check("R9", "no resync when high", n_start - s0, 1);
  endtask

  task automatic t_resync;
    int v0 = n_valid, s0 = n_start;
    send_char(8'h81, 8, 0, 0, (BIT_CLKS * 3) / 2, 1);
    send_char(8'h3C, 8, 0, 0, 0, 0); idle_bits(1);
    check("R9", "valid count", n_valid - v0, 2);
    check("R9", "start count", n_start - s0, 2);
    check("R9", "first data ferr", {prv_ferr, prv_data}, 9'h181);
    check("R9", "second data", {cap_ferr, cap_data}, 9'h03C);
  endtask

  task automatic t_break;
    int v0 = n_valid, c0 = n_chg;
    rxd = 1'b0; wait_clks(12 * BIT_CLKS);
    check("R7", "valid count", n_valid - v0, 1);
    check("R7", "data/brk/ferr", {cap_data, cap_brk, cap_ferr}, 10'h002);
    check("R7", "chg count", n_chg - c0, 1);
    rxd = 1'b1; wait_clks(1);
    rxd = 1'b0; wait_clks(2 * BIT_CLKS);
    check("R8", "one-edge high ignored", n_chg - c0, 1);
    check("R8", "no char during break", n_valid - v0, 1);
    idle_bits(1);
    check("R8", "end chg count", n_chg - c0, 2);
    send_char(8'h5A, 8, 0, 0, 0, 1); idle_bits(1);
    check("R8", "resume data", {cap_brk, cap_data}, 9'h05A);
  endtask

  task automatic t_enable;
    int v0 = n_valid, s0 = n_start;
    en = 1'b0;
    send_char(8'hC3, 8, 0, 0, 0, 1); idle_bits(1);
    check("R10", "disabled valid", n_valid - v0, 0);
    check("R10", "disabled start", n_start - s0, 0);
    en = 1'b1;
    fork
      send_char(8'hC3, 8, 0, 0, 0, 1);
      begin wait_clks(4 * BIT_CLKS); en = 1'b0; end
    join
    idle_bits(1);
    en = 1'b1;
    idle_bits(1);
    check("R10", "cut char dropped", n_valid - v0, 0);
    send_char(8'h96, 8, 0, 0, 0, 1); idle_bits(1);
    check("R10", "recovered data", cap_data, 8'h96);
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      finish_run();
    end
  end

  initial begin
    wait_clks(4);
    t_reset();
    rst_n = 1'b1;
    wait_clks(4);
    en = 1'b1;
    idle_bits(1);
    t_basic();
    t_length();
    t_parity();
    t_false_start();
    t_framing();
    t_resync();
    t_break();
    t_enable();
    finish_run();
  end

endmodule